// File: doc/BRIEF.md
# Masked Vector-Immediate Element ALU

This block executes one vector-immediate instruction over a packed vector register group, one element per clock. At a start pulse it captures the instruction word, the element width, the element count, the fixed-point rounding mode, the source vector, the old destination vector and the mask. It then walks the elements from index 0 upward. Each active element is replaced by the result of the selected operation on that element and the 5-bit immediate. Inactive elements, and elements at or above the count, keep their old destination value.

The operations are add, reverse subtract, AND, OR, XOR, unsigned and signed saturating add, logical left and right shifts, arithmetic right shift, and logical and arithmetic scaling right shifts with rounding. During the walk the element pointer is visible on `vstart`. A one-cycle `done` pulse marks the end of the walk, and `vstart` then returns to zero. A sticky flag reports whether any active element clamped in a saturating add.

Top module: `vi_imm_alu`

## Requirements
- R1: Instruction fields are decoded as follows: funct6 = bits 31:26, vm = bit 25, source register = bits 24:20, immediate = bits 19:15, destination register = bits 11:7. The two register fields appear on `src_reg` and `dst_reg` from the cycle after the start is accepted. The operation is performed only when bits 6:0 = 1010111 and bits 14:12 = 011 and funct6 is a listed code. Any other word leaves the destination vector equal to the old vector.
- R2: The immediate is sign-extended to SEW for add (000000), reverse subtract (000011, immediate minus element), AND (001001), OR (001010) and XOR (001011). Results wrap modulo 2^SEW.
- R3: Unsigned saturating add (100000) adds the sign-extended immediate to the element as unsigned values and clamps to all ones on carry-out. Signed saturating add (100001) clamps to the largest or smallest signed SEW value on overflow.
- R4: For left shift (100101), logical right shift (101000) and arithmetic right shift (101001), the shift amount is the zero-extended immediate reduced to its low log2(SEW) bits. The arithmetic shift fills with the element's sign bit.
- R5: The scaling shifts (101010 logical, 101011 arithmetic) add a rounding increment to the shifted value, chosen by `rnd_mode`. 00 adds the most significant dropped bit. 01 rounds to nearest, with ties to even. 10 adds nothing. 11 sets the result LSB when any dropped bit is 1 and the LSB is 0. A shift amount of 0 gives an increment of 0.
- R6: When vm = 0, element i is active only if mask bit i is 1. When vm = 1, all elements are active. Inactive elements keep their old destination value.
- R7: Elements with index at or above the effective count keep their old value. The effective count is `elem_cnt` clipped to VLEN/SEW.
- R8: `sew_sel` selects SEW: 00 = 8, 01 = 16, 10 = 32, 11 = 64. Element i occupies bits [i*SEW +: SEW] of every vector.
- R9: `done` is a one-cycle pulse in the (count+1)-th cycle after the start edge. `busy` is high from the start edge until `done`. A start that arrives while busy is ignored.
- R10: While busy, `vstart` holds the index of the next element to be processed. It reads 0 when idle, including the cycle in which `done` is high.
- R11: `sat_flag` clears when a start is accepted. It is set when an active element clamps in a saturating add, and it holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| instr | input | 32 | Instruction word |
| sew_sel | input | 2 | Element width select |
| elem_cnt | input | CW | Requested element count |
| rnd_mode | input | 2 | Fixed-point rounding mode |
| src_vec | input | VLEN | Source vector |
| old_vec | input | VLEN | Old destination vector |
| mask_vec | input | VLEN/8 | Per-element mask bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vstart | output | CW | Next element index |
| sat_flag | output | 1 | Sticky saturation indication |
| result_vec | output | VLEN | New destination vector |
| dst_reg | output | 5 | Captured destination register field |
| src_reg | output | 5 | Captured source register field |

## Verification
The hardest cases to reach are the rounding corner cases of the scaling shifts. These are exact ties between the dropped bits and half an LSB, an odd or even kept LSB, and a shift of zero. Each of these has to appear at every element width, combined with the mask and with the count clipping. The bench sweeps every immediate value against every rounding mode, every listed operation and every element width, and fills the elements with random data, so ties and all-zero dropped fields appear at the small shift amounts. It also draws random masks, random vm and counts past the capacity limit, so that active, masked-off and tail elements mix in every run.

// File: rtl/vi_pkg.sv
package vi_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_RSUB, OP_AND, OP_OR, OP_XOR, OP_SADDU, OP_SADD,
    OP_SLL, OP_SRL, OP_SRA, OP_SSRL, OP_SSRA
  } op_e;

  localparam logic [6:0] OPC_VEC  = 7'b1010111;
  localparam logic [2:0] FMT_VI   = 3'b011;

  localparam logic [5:0] F6_ADD   = 6'b000000;
  localparam logic [5:0] F6_RSUB  = 6'b000011;
  localparam logic [5:0] F6_AND   = 6'b001001;
  localparam logic [5:0] F6_OR    = 6'b001010;
  localparam logic [5:0] F6_XOR   = 6'b001011;
  localparam logic [5:0] F6_SADDU = 6'b100000;
  localparam logic [5:0] F6_SADD  = 6'b100001;
  localparam logic [5:0] F6_SLL   = 6'b100101;
  localparam logic [5:0] F6_SRL   = 6'b101000;
  localparam logic [5:0] F6_SRA   = 6'b101001;
  localparam logic [5:0] F6_SSRL  = 6'b101010;
  localparam logic [5:0] F6_SSRA  = 6'b101011;

  function automatic op_e f6_to_op(logic [5:0] f6);
    case (f6)
      F6_ADD:   return OP_ADD;
      F6_RSUB:  return OP_RSUB;
      F6_AND:   return OP_AND;
      F6_OR:    return OP_OR;
      F6_XOR:   return OP_XOR;
      F6_SADDU: return OP_SADDU;
      F6_SADD:  return OP_SADD;
      F6_SLL:   return OP_SLL;
      F6_SRL:   return OP_SRL;
      F6_SRA:   return OP_SRA;
      F6_SSRL:  return OP_SSRL;
      F6_SSRA:  return OP_SSRA;
      default:  return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vi_decode.sv
module vi_decode (
  input  logic [31:0]     instr,
  output vi_pkg::op_e     op,
  output logic            vm,
  output logic [4:0]      simm,
  output logic [4:0]      vd,
  output logic [4:0]      vs2
);
  logic fmt_ok;

  assign fmt_ok = (instr[6:0] == vi_pkg::OPC_VEC) && (instr[14:12] == vi_pkg::FMT_VI);
  assign op     = fmt_ok ? vi_pkg::f6_to_op(instr[31:26]) : vi_pkg::OP_NONE;
  assign vm     = instr[25];
  assign vs2    = instr[24:20];
  assign simm   = instr[19:15];
  assign vd     = instr[11:7];
endmodule

// File: rtl/vi_elem_alu.sv
module vi_elem_alu #(
  parameter int W = 8
) (
  input  vi_pkg::op_e     op,
  input  logic [W-1:0]    a,
  input  logic [4:0]      simm,
  input  logic [1:0]      rm,
  output logic [W-1:0]    y,
  output logic            sat
);
  import vi_pkg::*;

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] imm_s;
  logic [5:0]   amt;
  logic [W:0]   usum, ssum;
  logic         u_ov, s_ov;
  logic [W-1:0] srl_v, sra_v;

  function automatic logic rnd_incr(logic [W-1:0] v, logic [5:0] d, logic [1:0] m);
    logic half, rest, lsb;
    if (d == 6'd0) return 1'b0;
    half = |(v & (ONE << (d - 6'd1)));
    rest = |(v & ((ONE << (d - 6'd1)) - ONE));
    lsb  = |(v & (ONE << d));
    case (m)
      2'b00:   return half;
      2'b01:   return half & (rest | lsb);
      2'b10:   return 1'b0;
      default: return ~lsb & (half | rest);
    endcase
  endfunction

  assign imm_s = {{(W-5){simm[4]}}, simm};
  assign amt   = {1'b0, simm} & 6'(W-1);
  assign usum  = {1'b0, a} + {1'b0, imm_s};
  assign ssum  = {a[W-1], a} + {imm_s[W-1], imm_s};
  assign u_ov  = usum[W];
  assign s_ov  = ssum[W] ^ ssum[W-1];
  assign srl_v = a >> amt;
  assign sra_v = W'($signed(a) >>> amt);

  always_comb begin
    case (op)
      OP_ADD:   y = a + imm_s;
      OP_RSUB:  y = imm_s - a;
      OP_AND:   y = a & imm_s;
      OP_OR:    y = a | imm_s;
      OP_XOR:   y = a ^ imm_s;
      OP_SADDU: y = u_ov ? '1 : usum[W-1:0];
      OP_SADD:  y = s_ov ? (ssum[W] ? SMIN : SMAX) : ssum[W-1:0];
      OP_SLL:   y = a << amt;
      OP_SRL:   y = srl_v;
      OP_SRA:   y = sra_v;
      OP_SSRL:  y = srl_v + W'(rnd_incr(a, amt, rm));
      OP_SSRA:  y = sra_v + W'(rnd_incr(a, amt, rm));
      default:  y = a;
    endcase
    sat = ((op == OP_SADDU) && u_ov) || ((op == OP_SADD) && s_ov);
  end
endmodule

// File: rtl/vi_seq.sv
module vi_seq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] idx,
  output logic [CW-1:0] cnt_q,
  output logic          load,
  output logic          step
);
  assign load = start & ~busy;
  assign step = busy & (idx < cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      idx   <= '0;
      cnt_q <= cnt_in;
    end else if (busy) begin
      if (step) begin
        idx <= idx + 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        idx  <= '0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/vi_imm_alu.sv
module vi_imm_alu #(
  parameter int VLEN = 128,
  localparam int MAXE = VLEN / 8,
  localparam int CW   = $clog2(MAXE + 1),
  localparam int NW   = VLEN / 64,
  localparam int OFFW = $clog2(VLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [1:0]      sew_sel,
  input  logic [CW-1:0]   elem_cnt,
  input  logic [1:0]      rnd_mode,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] old_vec,
  input  logic [MAXE-1:0] mask_vec,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   vstart,
  output logic            sat_flag,
  output logic [VLEN-1:0] result_vec,
  output logic [4:0]      dst_reg,
  output logic [4:0]      src_reg
);
  import vi_pkg::*;

  op_e              dec_op, op_q;
  logic             dec_vm, vm_q;
  logic [4:0]       dec_simm, simm_q, dec_vd, dec_vs2;
  logic [1:0]       sew_q, rm_q;
  logic [MAXE-1:0]  mask_q;
  logic [63:0]      src_w [NW];
  logic [CW-1:0]    cap, cnt_eff, idx, cnt_q;
  logic             load_ok, step;
  logic [OFFW-1:0]  off;
  logic [63:0]      elem64, y_sel, sew_mask;
  logic [63:0]      alu_y [4];
  logic [3:0]       alu_sat;
  logic             elem_active, elem_fire, elem_sat;
  logic [VLEN-1:0]  wmask, wdata;

  vi_decode u_dec (
    .instr(instr), .op(dec_op), .vm(dec_vm), .simm(dec_simm),
    .vd(dec_vd), .vs2(dec_vs2)
  );

  assign cap     = CW'(MAXE >> sew_sel);
  assign cnt_eff = (elem_cnt > cap) ? cap : elem_cnt;

  vi_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_eff),
    .busy(busy), .done(done), .idx(idx), .cnt_q(cnt_q),
    .load(load_ok), .step(step)
  );
  assign vstart = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      vm_q    <= 1'b0;
      simm_q  <= '0;
      sew_q   <= '0;
      rm_q    <= '0;
      mask_q  <= '0;
      dst_reg <= '0;
      src_reg <= '0;
      for (int w = 0; w < NW; w++) src_w[w] <= '0;
    end else if (load_ok) begin
      op_q    <= dec_op;
      vm_q    <= dec_vm;
      simm_q  <= dec_simm;
      sew_q   <= sew_sel;
      rm_q    <= rnd_mode;
      mask_q  <= mask_vec;
      dst_reg <= dec_vd;
      src_reg <= dec_vs2;
      for (int w = 0; w < NW; w++) src_w[w] <= src_vec[w*64 +: 64];
    end
  end

  // element bit offset; elements never straddle a 64-bit word
  assign off    = OFFW'({idx, 3'b000} << sew_q);
  assign elem64 = src_w[off[OFFW-1:6]] >> off[5:0];

  for (genvar k = 0; k < 4; k++) begin : g_width
    localparam int W = 8 << k;
    logic [W-1:0] y_w;
    vi_elem_alu #(.W(W)) u_alu (
      .op(op_q), .a(elem64[W-1:0]), .simm(simm_q), .rm(rm_q),
      .y(y_w), .sat(alu_sat[k])
    );
    assign alu_y[k] = 64'(y_w);
  end

  always_comb begin
    y_sel    = alu_y[sew_q];
    elem_sat = alu_sat[sew_q];
    case (sew_q)
      2'd0:    sew_mask = 64'h0000_0000_0000_00FF;
      2'd1:    sew_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    sew_mask = 64'h0000_0000_FFFF_FFFF;
      default: sew_mask = '1;
    endcase
  end

  assign elem_active = vm_q | (|(mask_q & (MAXE'(1) << idx)));
  assign elem_fire   = step & elem_active & (op_q != OP_NONE);
  assign wmask       = {{(VLEN-64){1'b0}}, sew_mask} << off;
  assign wdata       = {{(VLEN-64){1'b0}}, y_sel} << off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_vec <= '0;
      sat_flag   <= 1'b0;
    end else if (load_ok) begin
      result_vec <= old_vec;
      sat_flag   <= 1'b0;
    end else if (elem_fire) begin
      result_vec <= (result_vec & ~wmask) | (wdata & wmask);
      if (elem_sat) sat_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/vi_alu_chk.sv
module vi_alu_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          load_ok,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] vstart,
  input logic [CW-1:0] cnt_q,
  input logic          elem_fire,
  input logic          sat_flag
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && vstart < cnt_q) |=> (busy && vstart == $past(vstart) + 1'b1));

  p_idle_vstart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> vstart == '0);

  p_vstart_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vstart <= cnt_q);

  p_sat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !sat_flag);

  p_sat_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !load_ok) |=> sat_flag);

  p_sat_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(elem_fire));
endmodule

bind vi_imm_alu vi_alu_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .load_ok(load_ok),
  .busy(busy), .done(done), .vstart(vstart), .cnt_q(cnt_q),
  .elem_fire(elem_fire), .sat_flag(sat_flag)
);

// File: tb/vi_imm_alu_tb_top.sv
module vi_imm_alu_tb_top;
  localparam int VLEN = 128;
  localparam int MAXE = VLEN / 8;
  localparam int CW   = $clog2(MAXE + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic [1:0]      sew_sel = '0;
  logic [CW-1:0]   elem_cnt = '0;
  logic [1:0]      rnd_mode = '0;
  logic [VLEN-1:0] src_vec = '0, old_vec = '0;
  logic [MAXE-1:0] mask_vec = '0;
  logic            busy, done, sat_flag;
  logic [CW-1:0]   vstart;
  logic [VLEN-1:0] result_vec;
  logic [4:0]      dst_reg, src_reg;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vi_imm_alu #(.VLEN(VLEN)) dut_i (.*);

  localparam logic [5:0] F6S [12] = '{6'b000000, 6'b000011, 6'b001001, 6'b001010,
    6'b001011, 6'b100000, 6'b100001, 6'b100101, 6'b101000, 6'b101001,
    6'b101010, 6'b101011};

  task automatic chk(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(logic [5:0] f6, logic vm, logic [4:0] vs2,
                                           logic [4:0] simm, logic [4:0] vd);
    return {f6, vm, vs2, simm, 3'b011, vd, 7'b1010111};
  endfunction

  // reference per element, written from the requirement text
  function automatic logic [63:0] ref_elem(logic [5:0] f6, int w, logic [63:0] a,
                                           logic [4:0] simm, logic [1:0] rm,
                                           output bit sat);
    logic [63:0] m, immv, sb, sa, base, dropped, half;
    logic [64:0] us;
    logic signed [65:0] sa66, im66, ss, smax, smin;
    int d;
    bit lsb, inc;
    m    = (w == 64) ? '1 : ((64'd1 << w) - 1);
    immv = {{59{simm[4]}}, simm} & m;
    sb   = 64'd1 << (w - 1);
    sa   = (a ^ sb) - sb;
    d    = int'(simm) % w;
    sat  = 0;
    case (f6)
      6'b000000: return (a + immv) & m;
      6'b000011: return (immv - a) & m;
      6'b001001: return a & immv;
      6'b001010: return a | immv;
      6'b001011: return a ^ immv;
      6'b100000: begin
        us = {1'b0, a} + {1'b0, immv};
        if (us > {1'b0, m}) begin sat = 1; return m; end
        return us[63:0];
      end
      6'b100001: begin
        sa66 = $signed({{2{sa[63]}}, sa});
        im66 = $signed({{61{simm[4]}}, simm});
        ss   = sa66 + im66;
        smax = (66'sd1 <<< (w - 1)) - 66'sd1;
        smin = -(66'sd1 <<< (w - 1));
        if (ss > smax) begin sat = 1; ss = smax; end
        else if (ss < smin) begin sat = 1; ss = smin; end
        return ss[63:0] & m;
      end
      6'b100101: return (a << d) & m;
      6'b101000: return a >> d;
      6'b101001: return 64'($signed(sa) >>> d) & m;
      default: begin
        base = (f6 == 6'b101010) ? (a >> d) : (64'($signed(sa) >>> d) & m);
        if (d == 0) return base;
        dropped = a & ((64'd1 << d) - 1);
        half    = 64'd1 << (d - 1);
        lsb     = base[0];
        case (rm)
          2'b00: inc = dropped >= half;
          2'b01: inc = (dropped > half) || (dropped == half && lsb);
          2'b10: inc = 0;
          default: inc = (dropped != 0) && !lsb;
        endcase
        return (base + 64'(inc)) & m;
      end
    endcase
  endfunction

  task automatic expect_vec(logic [5:0] f6, bit valid, logic vm, logic [4:0] simm, int sk,
                            int cnt, logic [1:0] rm, logic [VLEN-1:0] src,
                            logic [VLEN-1:0] old, logic [MAXE-1:0] msk,
                            output logic [VLEN-1:0] ev, output bit es, output int ce);
    int w = 8 << sk;
    int cap = VLEN / w;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    ev = old;
    es = 0;
    ce = (cnt > cap) ? cap : cnt;
    for (int i = 0; i < ce; i++) begin
      logic [63:0] a, r;
      bit s;
      a = 64'(src >> (i * w)) & m;
      if (valid && (vm || msk[i])) begin
        r  = ref_elem(f6, w, a, simm, rm, s);
        es = es | s;
        ev = (ev & ~({{(VLEN-64){1'b0}}, m} << (i * w))) | ({{(VLEN-64){1'b0}}, r} << (i * w));
      end
    end
  endtask

  task automatic launch(logic [31:0] ins, int sk, int cnt, logic [1:0] rm,
                        logic [VLEN-1:0] src, logic [VLEN-1:0] old, logic [MAXE-1:0] msk,
                        output int lat);
    @(negedge clk);
    instr = ins; sew_sel = 2'(sk); elem_cnt = CW'(cnt); rnd_mode = rm;
    src_vec = src; old_vec = old; mask_vec = msk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(logic [5:0] f6, logic vm, logic [4:0] simm, int sk, int cnt,
                          logic [1:0] rm, logic [VLEN-1:0] src, logic [VLEN-1:0] old,
                          logic [MAXE-1:0] msk);
    logic [VLEN-1:0] ev;
    bit es;
    int ce, lat;
    expect_vec(f6, 1, vm, simm, sk, cnt, rm, src, old, msk, ev, es, ce);
    launch(mk_instr(f6, vm, 5'd3, simm, 5'd9), sk, cnt, rm, src, old, msk, lat);
    chk(result_vec == ev, $sformatf("R2-R8 data f6=%b sew=%0d imm=%0d rm=%0d vm=%0d (R2 R3 R4 R5 R6 R7 R8)",
        f6, 8 << sk, simm, rm, vm), result_vec, ev);
    chk(sat_flag == es, "R11 R3 sat_flag", VLEN'(sat_flag), VLEN'(es));
    chk(lat == ce + 1, "R9 done latency", VLEN'(lat), VLEN'(ce + 1));
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] src, old, ev;
    bit es;
    int ce, lat;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    // reset state: R9 R10 R11
    chk(!busy && !done, "R9 reset busy/done", VLEN'({busy, done}), '0);
    chk(vstart == 0, "R10 reset vstart", VLEN'(vstart), '0);
    chk(!sat_flag && result_vec == '0, "R11 reset sat/result", result_vec, '0);
    rst_n = 1'b1;

    // sweep: every operation x width x immediate x rounding mode
    for (int sk = 0; sk < 4; sk++)
      for (int o = 0; o < 12; o++)
        for (int im = 0; im < 32; im++)
          for (int rm = 0; rm < 4; rm++) begin
            int cap = MAXE >> sk;
            run_case(F6S[o], 1'($urandom), 5'(im), sk, int'($urandom_range(0, cap + 2)),
                     2'(rm), rnd_vec(), rnd_vec(), MAXE'($urandom));
          end

    // R1: wrong major opcode leaves destination unchanged
    src = rnd_vec(); old = rnd_vec();
    launch({6'b000000, 1'b1, 5'd1, 5'd5, 3'b011, 5'd2, 7'b0010011}, 0, 16, 0, src, old, '1, lat);
    chk(result_vec == old, "R1 wrong opcode", result_vec, old);
    // R1: wrong funct3 leaves destination unchanged
    launch({6'b000000, 1'b1, 5'd1, 5'd5, 3'b000, 5'd2, 7'b1010111}, 0, 16, 0, src, old, '1, lat);
    chk(result_vec == old, "R1 wrong format", result_vec, old);
    // R1: unlisted funct6 leaves destination unchanged
    launch(mk_instr(6'b000001, 1'b1, 5'd1, 5'd5, 5'd2), 1, 8, 0, src, old, '1, lat);
    chk(result_vec == old, "R1 unlisted funct6", result_vec, old);
    // R1: register fields
    launch(mk_instr(6'b000000, 1'b1, 5'd22, 5'd1, 5'd17), 2, 4, 0, src, old, '1, lat);
    chk(dst_reg == 5'd17, "R1 dst_reg", VLEN'(dst_reg), VLEN'(17));
    chk(src_reg == 5'd22, "R1 src_reg", VLEN'(src_reg), VLEN'(22));

    // R9 R10: vstart progression and start ignored while busy
    src = rnd_vec(); old = rnd_vec();
    expect_vec(6'b000000, 1, 1'b1, 5'd1, 0, 6, 0, src, old, '0, ev, es, ce);
    @(negedge clk);
    instr = mk_instr(6'b000000, 1'b1, 5'd0, 5'd1, 5'd0); sew_sel = 0; elem_cnt = 6;
    src_vec = src; old_vec = old; mask_vec = '0; start = 1'b1;
    @(negedge clk);
    instr = mk_instr(6'b001011, 1'b1, 5'd0, 5'd7, 5'd0); old_vec = rnd_vec();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(vstart == CW'(k), "R10 vstart while busy", VLEN'(vstart), VLEN'(k));
    end
    start = 1'b0;
    @(negedge clk);
    chk(done && vstart == 0, "R10 vstart zero at done", VLEN'(vstart), '0);
    chk(result_vec == ev, "R9 start while busy ignored", result_vec, ev);

    // R11: flag holds while idle after a clamp
    launch(mk_instr(6'b100000, 1'b1, 5'd0, 5'd31, 5'd0), 0, 16, 0, '1, '0, '0, lat);
    repeat (4) @(negedge clk);
    chk(sat_flag, "R11 sat held idle", VLEN'(sat_flag), VLEN'(1));
    // R6: vm=0 with empty mask keeps everything
    old = rnd_vec();
    launch(mk_instr(6'b000000, 1'b0, 5'd0, 5'd3, 5'd0), 0, 16, 0, rnd_vec(), old, '0, lat);
    chk(result_vec == old, "R6 all masked off", result_vec, old);
    chk(!sat_flag, "R11 sat cleared by start", VLEN'(sat_flag), '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule